// File: doc/BRIEF.md
# Write-Once Security Lock Controller

This block decides whether a chip is sealed against outside access. It holds a 32-bit key word in a behavioural model of nonvolatile cells, arranged as four byte cells. These cells are not cleared by reset. Software can place a value in a volatile staging register, copy it into the cells with a commit request, or clear the cells with an erase request. When reset is released, the stored word is compared bit by bit with the fixed pattern 0x50536F43. If at least 28 of the 32 bits agree, the block enters its sealed state for the whole time until the next reset. The test, debug and programming enables are then held low, and every further change to the cells is refused.

A tolerant threshold is used so that a few weak cells cannot unseal a part. Because the decision is taken only at reset release, a newly committed key has no effect until the part is reset. Key loads and commits are refused while the flash-protection input is high. The stored word is always visible on a read-back port, so a sealed part can still be identified.

The control is a three-state machine. In reset the machine sits in SAMPLE. On the first clock edge after release it takes SAMPLE→OPEN when the match count is below threshold, or SAMPLE→LOCKED when it is at or above threshold. OPEN and LOCKED each hold until the next reset. Every request gets a one-cycle done pulse, with an error flag when the request was refused.

Top module: `keylatch_lock`

## Requirements
- R1: The stored word is 32 bits wide and `rdback_o` always shows it, in every state, including while sealed.
- R2: `rst_n` is a synchronous, active-low reset. While it is low, and in the first cycle after it rises, all three enables are 0. After the first rising clock edge with `rst_n` high, `lock_o` is 1 exactly when at least 28 bits of the stored word equal the corresponding bits of 0x50536F43, and 0 otherwise.
- R3: `lock_o` does not change between resets, even when a commit or erase changes the stored word.
- R4: When `lock_o` is 0 after the sample cycle, `dbg_en_o`, `test_en_o` and `prog_en_o` are all 1. When `lock_o` is 1, all three are 0.
- R5: While sealed, every erase, load and commit request is refused with `err_o`=1, and `rdback_o` is left unchanged.
- R6: When `flash_prot_i` is 1, a load (op 2'b01) or a commit (op 2'b10) is refused with `err_o`=1 and changes nothing. An erase (op 2'b11) is not affected by `flash_prot_i`.
- R7: For a request seen on a clock edge, `done_o` is 1 for exactly the next cycle. `err_o` is 0 when the request was accepted. Op 2'b00 and any request arriving in the sample cycle are refused.
- R8: A load writes `req_data` only into the staging register and leaves `rdback_o` unchanged. A commit copies the staging register into the cells. An erase clears the cells to zero.
- R9: Reset clears the staging register to zero. The stored cells keep their contents across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; its release triggers the lock decision |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 2 | 01 load, 10 commit, 11 erase, 00 invalid |
| req_data | input | 32 | Key value for a load |
| flash_prot_i | input | 1 | Flash protection active; refuses load and commit |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request refused; valid while done_o is 1 |
| lock_o | output | 1 | Sealed state |
| dbg_en_o | output | 1 | Debug access enable |
| test_en_o | output | 1 | Test access enable |
| prog_en_o | output | 1 | Programming access enable |
| rdback_o | output | 32 | Stored word read-back |

## Verification
Two events can fall in the same cycle: the lock decision taken in the sample cycle right after reset release, and a request that would change the very word being judged. The bench provokes this by raising `rst_n` and presenting an erase in that same cycle. It then expects the request to be refused, the cells to keep their value, and `lock_o` to reflect the word as it was before the erase. The threshold itself is swept with random masks at every mismatch count from 32 down to 5, and then at 4. Expected values are computed from a popcount in the bench.

// File: rtl/keylatch_pkg.sv
package keylatch_pkg;
    localparam int KEY_W = 32;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_LOAD   = 2'b01,
        OP_COMMIT = 2'b10,
        OP_ERASE  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_OPEN   = 2'd1,
        ST_LOCKED = 2'd2
    } state_e;
endpackage

// File: rtl/keylatch_cells.sv
// Behavioural stand-in for the nonvolatile cells: no reset, byte-organised.
module keylatch_cells #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] word_o
);
    localparam int NBYTES = WIDTH / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [7:0] cell_q;
        always_ff @(posedge clk) begin
            if (wr_en) begin
                cell_q <= wr_data[b*8 +: 8];
            end
        end
        assign word_o[b*8 +: 8] = cell_q;
    end
endmodule

// File: rtl/keylatch_match.sv
// Counts bits that agree with the pattern and compares with the threshold.
module keylatch_match #(
    parameter int               WIDTH   = 32,
    parameter logic [WIDTH-1:0] PATTERN = 32'h5053_6F43,
    parameter int               THRESH  = 28
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             match_o
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    logic [WIDTH-1:0] agree;
    logic [CNT_W-1:0] count;

    assign agree = ~(word_i ^ PATTERN);

    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            count = count + CNT_W'(agree[i]);
        end
    end

    assign match_o = (count >= CNT_W'(THRESH));
endmodule

// File: rtl/keylatch_fsm.sv
module keylatch_fsm
    import keylatch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match_i,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic       flash_prot_i,
    output state_e     state_o,
    output logic       stage_we,
    output logic       cell_we,
    output logic       cell_clr,
    output logic       done_o,
    output logic       err_o
);
    state_e state_q, state_d;
    logic   reject;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE: state_d = match_i ? ST_LOCKED : ST_OPEN;
            ST_OPEN:   state_d = ST_OPEN;
            ST_LOCKED: state_d = ST_LOCKED;
            default:   state_d = ST_SAMPLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SAMPLE;
        else        state_q <= state_d;
    end

    // outputs: request decode per state
    always_comb begin
        stage_we = 1'b0;
        cell_we  = 1'b0;
        cell_clr = 1'b0;
        reject   = 1'b0;
        unique case (state_q)
            ST_SAMPLE: reject = req_valid;
            ST_LOCKED: reject = req_valid;
            ST_OPEN: begin
                if (req_valid) begin
                    unique case (op_e'(req_op))
                        OP_LOAD: begin
                            if (flash_prot_i) reject = 1'b1;
                            else              stage_we = 1'b1;
                        end
                        OP_COMMIT: begin
                            if (flash_prot_i) reject = 1'b1;
                            else              cell_we = 1'b1;
                        end
                        OP_ERASE: cell_clr = 1'b1;
                        OP_NONE:  reject   = 1'b1;
                        default:  reject   = 1'b1;
                    endcase
                end
            end
            default: reject = req_valid;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= req_valid;
            err_o  <= reject;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/keylatch_lock.sv
module keylatch_lock
    import keylatch_pkg::*;
#(
    parameter int               WIDTH   = KEY_W,
    parameter logic [WIDTH-1:0] PATTERN = 32'h5053_6F43,
    parameter int               THRESH  = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [WIDTH-1:0] req_data,
    input  logic             flash_prot_i,
    output logic             done_o,
    output logic             err_o,
    output logic             lock_o,
    output logic             dbg_en_o,
    output logic             test_en_o,
    output logic             prog_en_o,
    output logic [WIDTH-1:0] rdback_o
);
    state_e           state;
    logic             stage_we, cell_we, cell_clr, match;
    logic [WIDTH-1:0] stage_q, cell_word;

    // volatile staging register
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q <= '0;
        else if (stage_we) stage_q <= req_data;
    end

    keylatch_cells #(.WIDTH(WIDTH)) u_cells (
        .clk     (clk),
        .wr_en   (cell_we | cell_clr),
        .wr_data (cell_clr ? '0 : stage_q),
        .word_o  (cell_word)
    );

    keylatch_match #(.WIDTH(WIDTH), .PATTERN(PATTERN), .THRESH(THRESH)) u_match (
        .word_i  (cell_word),
        .match_o (match)
    );

    keylatch_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .match_i      (match),
        .req_valid    (req_valid),
        .req_op       (req_op),
        .flash_prot_i (flash_prot_i),
        .state_o      (state),
        .stage_we     (stage_we),
        .cell_we      (cell_we),
        .cell_clr     (cell_clr),
        .done_o       (done_o),
        .err_o        (err_o)
    );

    assign lock_o    = (state == ST_LOCKED);
    assign dbg_en_o  = (state == ST_OPEN);
    assign test_en_o = (state == ST_OPEN);
    assign prog_en_o = (state == ST_OPEN);
    assign rdback_o  = cell_word;
endmodule

// File: rtl/keylatch_lock_chk.sv
module keylatch_lock_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic             flash_prot_i,
    input logic             done_o,
    input logic             err_o,
    input logic             lock_o,
    input logic             dbg_en_o,
    input logic             test_en_o,
    input logic             prog_en_o,
    input logic [WIDTH-1:0] rdback_o
);
    AST_LOCK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> (!dbg_en_o && !test_en_o && !prog_en_o)); // R4

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o); // R3

    AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_o && dbg_en_o) |=> !lock_o); // R3

    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> $stable(rdback_o)); // R5

    AST_PROT_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && flash_prot_i && (req_op == 2'b01 || req_op == 2'b10)) |=> err_o); // R6

    AST_PROT_COMMIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && flash_prot_i && req_op == 2'b10) |=> $stable(rdback_o)); // R6

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done_o); // R7

    AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(req_valid)); // R7
endmodule

bind keylatch_lock keylatch_lock_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .flash_prot_i (flash_prot_i),
    .done_o       (done_o),
    .err_o        (err_o),
    .lock_o       (lock_o),
    .dbg_en_o     (dbg_en_o),
    .test_en_o    (test_en_o),
    .prog_en_o    (prog_en_o),
    .rdback_o     (rdback_o)
);

// File: tb/sim_keylatch_lock.sv
`timescale 1ns/1ps
module sim_keylatch_lock;
    localparam logic [31:0] PAT = 32'h5053_6F43;
    localparam logic [1:0] LOAD = 2'b01, COMMIT = 2'b10, ERASE = 2'b11, NONE = 2'b00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_data = '0;
    logic        flash_prot_i = 1'b0;
    logic        done_o, err_o, lock_o, dbg_en_o, test_en_o, prog_en_o;
    logic [31:0] rdback_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    keylatch_lock u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .flash_prot_i(flash_prot_i), .done_o(done_o),
        .err_o(err_o), .lock_o(lock_o), .dbg_en_o(dbg_en_o),
        .test_en_o(test_en_o), .prog_en_o(prog_en_o), .rdback_o(rdback_o)
    );

    function automatic logic exp_lock(input logic [31:0] w);
        return $countones(~(w ^ PAT)) >= 28;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one request; done/err sampled at the following negedge
    task automatic do_req(input logic [1:0] op, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_op = NONE;
    endtask

    // reset pulse; optionally a request in the sample cycle
    task automatic reset_pulse(input logic with_req, input logic [1:0] op);
        logic en;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        en = dbg_en_o | test_en_o | prog_en_o;
        chk(en == 1'b0, "R2", "enables in sample cycle", {31'd0, en}, 32'd0);
        if (with_req) begin
            req_valid = 1'b1; req_op = op; req_data = '0;
        end
        @(negedge clk);
        req_valid = 1'b0; req_op = NONE;
    endtask

    task automatic check_state(input logic [31:0] w, input string tag);
        logic le;
        le = exp_lock(w);
        chk(rdback_o == w, "R1", {tag, " readback"}, rdback_o, w);
        chk(lock_o == le, "R2", {tag, " lock"}, {31'd0, lock_o}, {31'd0, le});
        chk({dbg_en_o, test_en_o, prog_en_o} == {3{~le}}, "R4", {tag, " enables"},
            {29'd0, dbg_en_o, test_en_o, prog_en_o}, {29'd0, {3{~le}}});
    endtask

    task automatic program_word(input logic [31:0] w);
        do_req(LOAD, w);
        chk(done_o && !err_o, "R8", "load accepted", {30'd0, done_o, err_o}, 32'd2);
        do_req(COMMIT, '0);
        chk(done_o && !err_o, "R8", "commit accepted", {30'd0, done_o, err_o}, 32'd2);
        chk(rdback_o == w, "R8", "commit copies stage", rdback_o, w);
    endtask

    function automatic logic [31:0] rand_mask(input int k);
        logic [31:0] m = '0;
        while ($countones(m) < k) m[$urandom_range(31, 0)] = 1'b1;
        return m;
    endfunction

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog all-R actual=%0d expected<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] w, keep;
        repeat (3) @(negedge clk);
        chk(!done_o && !err_o, "R7", "reset done/err", {30'd0, done_o, err_o}, 32'd0);
        reset_pulse(1'b0, NONE);
        check_state(rdback_o, "powerup");

        // start from a known unlocked word
        do_req(ERASE, '0);
        chk(rdback_o == 32'd0, "R8", "erase clears", rdback_o, 32'd0);

        // R8: load alone does not touch the cells
        do_req(LOAD, 32'hA5A5_1234);
        chk(rdback_o == 32'd0, "R8", "load leaves cells", rdback_o, 32'd0);

        // R9: staging is volatile, cells are not
        program_word(32'h1357_9BDF);
        do_req(LOAD, 32'hFFFF_0000);
        reset_pulse(1'b0, NONE);
        chk(rdback_o == 32'h1357_9BDF, "R9", "cells kept over reset", rdback_o, 32'h1357_9BDF);
        do_req(COMMIT, '0);
        chk(rdback_o == 32'd0, "R9", "stage cleared by reset", rdback_o, 32'd0);

        // R7: invalid op and pulse width
        do_req(NONE, '0);
        chk(done_o && err_o, "R7", "op 00 refused", {30'd0, done_o, err_o}, 32'd3);
        @(negedge clk);
        chk(!done_o, "R7", "done one cycle", {31'd0, done_o}, 32'd0);

        // R6: flash protection
        program_word(32'h0F0F_0F0F);
        flash_prot_i = 1'b1;
        do_req(LOAD, 32'h7777_7777);
        chk(done_o && err_o, "R6", "load refused", {30'd0, done_o, err_o}, 32'd3);
        do_req(COMMIT, '0);
        chk(done_o && err_o, "R6", "commit refused", {30'd0, done_o, err_o}, 32'd3);
        chk(rdback_o == 32'h0F0F_0F0F, "R6", "cells unchanged", rdback_o, 32'h0F0F_0F0F);
        do_req(ERASE, '0);
        chk(done_o && !err_o && rdback_o == 0, "R6", "erase allowed", rdback_o, 32'd0);
        flash_prot_i = 1'b0;
        do_req(COMMIT, '0);
        chk(rdback_o == 32'h0F0F_0F0F, "R6", "stage kept its old value", rdback_o, 32'h0F0F_0F0F);

        // R3: committing the exact pattern does not lock before reset
        program_word(PAT);
        repeat (4) @(negedge clk);
        chk(!lock_o && dbg_en_o && test_en_o && prog_en_o, "R3", "no lock before reset",
            {28'd0, lock_o, dbg_en_o, test_en_o, prog_en_o}, 32'd7);
        do_req(ERASE, '0);

        // sample-cycle collision: erase in the first cycle after release
        w = PAT ^ rand_mask(6);
        program_word(w);
        reset_pulse(1'b1, ERASE);
        chk(done_o && err_o, "R7", "sample-cycle request refused", {30'd0, done_o, err_o}, 32'd3);
        check_state(w, "collision");

        // threshold sweep, unlocked side
        for (int k = 32; k >= 5; k--) begin
            for (int j = 0; j < 3; j++) begin
                w = PAT ^ rand_mask(k);
                do_req(ERASE, '0);
                program_word(w);
                reset_pulse(1'b0, NONE);
                check_state(w, $sformatf("k=%0d", k));
            end
        end

        // R2: four mismatches locks
        w = PAT ^ rand_mask(4);
        do_req(ERASE, '0);
        program_word(w);
        chk(!lock_o, "R3", "still open after commit", {31'd0, lock_o}, 32'd0);
        reset_pulse(1'b0, NONE);
        check_state(w, "k=4");

        // R5: sealed part ignores everything
        keep = rdback_o;
        do_req(ERASE, '0);
        chk(done_o && err_o, "R5", "erase refused", {30'd0, done_o, err_o}, 32'd3);
        do_req(LOAD, 32'h1111_1111);
        chk(done_o && err_o, "R5", "load refused", {30'd0, done_o, err_o}, 32'd3);
        do_req(COMMIT, '0);
        chk(done_o && err_o, "R5", "commit refused", {30'd0, done_o, err_o}, 32'd3);
        chk(rdback_o == keep, "R5", "cells frozen", rdback_o, keep);
        reset_pulse(1'b0, NONE);
        check_state(keep, "relock");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule